// File: doc/BRIEF.md
# Snoop Control Register Bank

This block is the software-visible register file of a multi-core cluster's snoop control unit. It decodes a 256-byte window on a simple single-cycle request bus. It accepts 1-, 2- and 4-byte accesses at any byte offset and returns read data one cycle after each request. It holds a one-bit enable flag and a 32-bit per-core power status word that can be updated one byte lane at a time. It also presents a read-only configuration word, which is computed from the number of cores the cluster is built with.

Several offsets are placeholders for features the unit does not model: an invalidate command, address filtering bounds and access control words. They read as zero and ignore writes. An access whose size is not 1, 2 or 4 bytes is refused: it changes no state, and the block raises an error strobe together with the response.

Top module: `scu_regbank`

## Requirements
- R1: After reset, the enable flag and the power status word are zero, `rsp_error` is low and `rsp_rdata` is zero.
- R2: A write to offset 0x00 stores only bit 0 of `req_wdata` as the enable flag. A read of offset 0x00 returns the flag in bit 0 and zeros above it.
- R3: A read of offset 0x04 returns ((2^NUM_CORES − 1) << 4) | (NUM_CORES − 1), which is 0xF3 for four cores. Writes to 0x04 change nothing.
- R4: A write at offset 0x08+k (k = 0..3) replaces the power status bits under the size mask shifted left by 8·k with the correspondingly masked and shifted write data, and keeps all other bits. Bits shifted past bit 31 are dropped.
- R5: `req_size` is a byte count. 1 selects mask 0xFF, 2 selects 0xFFFF and 4 selects 0xFFFFFFFF. Any other value is rejected and changes neither register.
- R6: A read at offset 0x08+k returns the power status word logically shifted right by 8·k.
- R7: A request with a rejected size pulses `rsp_error` high for exactly the cycle after the request. For a rejected read, `rsp_rdata` is zero in that cycle. Accepted requests leave `rsp_error` low.
- R8: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other undecoded offset (including 0x01–0x03 and 0x05–0x07) read as zero and ignore writes.
- R9: `rsp_rdata` is updated on the first rising edge after a read request and holds its value through cycles that carry no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Registered read data |
| rsp_error | output | 1 | One-cycle strobe for a rejected access size |

## Verification
A wrongly merged power status word stays hidden until software reads it back. A read at 0x08 then shows the bad lane on the next cycle, and reads at 0x09–0x0B show whether the shift direction or the truncation at bit 31 went wrong. A flag that is not reduced to one bit, or a rejected access that still updates state, shows up on the first read of the affected offset after it. An error strobe that is missing or stretched is visible in the cycle right after the offending request.

// File: rtl/scu_regbank.sv
module scu_regbank #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_error
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-3:0] PWR_WORD = (ADDR_W-2)'(2);
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'((((1 << NUM_CORES) - 1) << 4) | (NUM_CORES - 1));

  logic              en_q;
  logic [DATA_W-1:0] pwr_q;

  logic              size_ok;
  logic [DATA_W-1:0] lane_mask;
  logic              hit_pwr;
  logic [4:0]        lane_shift;
  logic [DATA_W-1:0] wmask_sh;
  logic [DATA_W-1:0] wdata_sh;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    size_ok   = 1'b1;
    lane_mask = '0;
    case (req_size)
      SIZE_W'(1): lane_mask = DATA_W'(32'h0000_00FF);
      SIZE_W'(2): lane_mask = DATA_W'(32'h0000_FFFF);
      SIZE_W'(4): lane_mask = DATA_W'(32'hFFFF_FFFF);
      default:    size_ok   = 1'b0;
    endcase
  end

  assign hit_pwr    = (req_addr[ADDR_W-1:2] == PWR_WORD);
  assign lane_shift = {req_addr[1:0], 3'b000};
  assign wmask_sh   = lane_mask << lane_shift;
  assign wdata_sh   = (req_wdata & lane_mask) << lane_shift;

  always_comb begin
    rd_val = '0;
    if (req_addr == OFS_CTRL)
      rd_val = DATA_W'(en_q);
    else if (req_addr == OFS_CFG)
      rd_val = CFG_WORD;
    else if (hit_pwr)
      rd_val = pwr_q >> lane_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pwr_q <= '0;
    end else if (req_valid && req_write && size_ok) begin
      if (req_addr == OFS_CTRL)
        en_q <= req_wdata[0];
      if (hit_pwr)
        pwr_q <= (pwr_q & ~wmask_sh) | wdata_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_error <= 1'b0;
    end else begin
      rsp_error <= req_valid && !size_ok;
      if (req_valid && !req_write)
        rsp_rdata <= size_ok ? rd_val : '0;
    end
  end

  a_r7_err_only_after_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> $past(req_valid) && !($past(req_size) inside {SIZE_W'(1), SIZE_W'(2), SIZE_W'(4)}));

  a_r5_bad_size_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_size inside {SIZE_W'(1), SIZE_W'(2), SIZE_W'(4)}))
      |=> $stable(pwr_q) && $stable(en_q));

  a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_CTRL) |=> rsp_rdata[DATA_W-1:1] == '0);

  a_r3_cfg_constant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFS_CFG && size_ok) |=> rsp_rdata == CFG_WORD);

  a_r8_holes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr != OFS_CTRL && req_addr != OFS_CFG && !hit_pwr)
      |=> rsp_rdata == '0);

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));

  a_r4_pwr_only_by_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && hit_pwr) |=> $stable(pwr_q));

endmodule

// File: tb/test_scu_regbank.sv
module test_scu_regbank;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 8'h00, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd2},
    '{1'b1, 8'h00, 3'd4, 32'hFFFF_FFFF,  32'h0,         1'b0, 4'd2},
    '{1'b0, 8'h00, 3'd4, 32'h0,          32'h0000_0001, 1'b0, 4'd2},
    '{1'b0, 8'h04, 3'd4, 32'h0,          32'h0000_00F3, 1'b0, 4'd3},
    '{1'b1, 8'h04, 3'd4, 32'h0,          32'h0,         1'b0, 4'd3},
    '{1'b0, 8'h04, 3'd1, 32'h0,          32'h0000_00F3, 1'b0, 4'd3},
    '{1'b1, 8'h08, 3'd4, 32'h1122_3344,  32'h0,         1'b0, 4'd4},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'h1122_3344, 1'b0, 4'd6},
    '{1'b0, 8'h09, 3'd4, 32'h0,          32'h0011_2233, 1'b0, 4'd6},
    '{1'b0, 8'h0B, 3'd1, 32'h0,          32'h0000_0011, 1'b0, 4'd6},
    '{1'b1, 8'h09, 3'd1, 32'hAAAA_AAFF,  32'h0,         1'b0, 4'd4},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'h1122_FF44, 1'b0, 4'd4},
    '{1'b1, 8'h0A, 3'd2, 32'h0000_BEEF,  32'h0,         1'b0, 4'd5},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'hBEEF_FF44, 1'b0, 4'd5},
    '{1'b1, 8'h0B, 3'd2, 32'h1234_5678,  32'h0,         1'b0, 4'd4},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'h78EF_FF44, 1'b0, 4'd4},
    '{1'b1, 8'h09, 3'd4, 32'hCAFE_BABE,  32'h0,         1'b0, 4'd4},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'hFEBA_BE44, 1'b0, 4'd4},
    '{1'b0, 8'h0A, 3'd2, 32'h0,          32'h0000_FEBA, 1'b0, 4'd6},
    '{1'b1, 8'h08, 3'd3, 32'h0,          32'h0,         1'b1, 4'd5},
    '{1'b1, 8'h00, 3'd0, 32'h0,          32'h0,         1'b1, 4'd5},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'hFEBA_BE44, 1'b0, 4'd5},
    '{1'b0, 8'h00, 3'd4, 32'h0,          32'h0000_0001, 1'b0, 4'd5},
    '{1'b0, 8'h08, 3'd7, 32'h0,          32'h0000_0000, 1'b1, 4'd7},
    '{1'b1, 8'h0C, 3'd4, 32'hFFFF_FFFF,  32'h0,         1'b0, 4'd8},
    '{1'b0, 8'h0C, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b1, 8'h40, 3'd4, 32'hFFFF_FFFF,  32'h0,         1'b0, 4'd8},
    '{1'b0, 8'h40, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b0, 8'h44, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b0, 8'h50, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b0, 8'h54, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b0, 8'h01, 3'd1, 32'h0,          32'h0000_0000, 1'b0, 4'd8},
    '{1'b1, 8'h07, 3'd1, 32'hFFFF_FFFF,  32'h0,         1'b0, 4'd8},
    '{1'b0, 8'h08, 3'd4, 32'h0,          32'hFEBA_BE44, 1'b0, 4'd8},
    '{1'b1, 8'h00, 3'd1, 32'h0000_0002,  32'h0,         1'b0, 4'd2},
    '{1'b0, 8'h00, 3'd2, 32'h0,          32'h0000_0000, 1'b0, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_error;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scu_regbank i_scu_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_error(rsp_error)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                       input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(negedge clk);
    check("R1 rdata in reset", rsp_rdata, 32'h0);
    check("R1 error in reset", {31'b0, rsp_error}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      check($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, rsp_error}, {31'b0, VECS[i].err});
      if (!VECS[i].wr)
        check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rsp_rdata, VECS[i].exp);
    end

    // R7: strobe lasts exactly one cycle
    issue(1'b0, 8'h04, 3'd5, 32'h0);
    check("R7 strobe high", {31'b0, rsp_error}, 32'h1);
    @(negedge clk);
    check("R7 strobe drops", {31'b0, rsp_error}, 32'h0);

    // R9: read data holds across idle cycles and writes
    issue(1'b0, 8'h04, 3'd4, 32'h0);
    held = rsp_rdata;
    repeat (3) @(negedge clk);
    issue(1'b1, 8'h08, 3'd4, 32'h5555_AAAA);
    check("R9 hold after idle and write", rsp_rdata, held);

    // R1: reset mid-run clears both registers
    issue(1'b1, 8'h00, 3'd4, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rdata cleared", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b0, 8'h00, 3'd4, 32'h0);
    check("R1 enable after reset", rsp_rdata, 32'h0);
    issue(1'b0, 8'h08, 3'd4, 32'h0);
    check("R1 power after reset", rsp_rdata, 32'h0);

    // R4: full byte-lane walk, one lane at a time
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, 8'h08 + 8'(k), 3'd1, 32'hFFFF_FF00 | 32'(8'h10 * (k + 1)));
    end
    issue(1'b0, 8'h08, 3'd4, 32'h0);
    check("R4 lane walk", rsp_rdata, 32'h4030_2010);
    issue(1'b0, 8'h0B, 3'd4, 32'h0);
    check("R6 top lane", rsp_rdata, 32'h0000_0040);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule